// File: doc/BRIEF.md
# Calendar Alarm Comparator with Interrupt

This block holds a programmed alarm time and compares it against calendar fields supplied by an external time-keeping counter. The counter raises a one-cycle `secTick` whenever it has loaded new field values. In that cycle the block compares the fields with the alarm registers. A two-bit match-mode selector sets how many fields take part in the comparison.

A match sets a sticky alarm status bit. That bit latches even while the alarm interrupt is masked, so enabling the interrupt later raises `irq` at once. Software clears the status by writing a one to it. Bit 0 of both the status register and the enable register is reserved and always reads as one.

All registers are 16 bits wide and sit on a simple synchronous write port. Reads are combinational and use a separate read address.

Top module: `alarm_cmp`

## Requirements
- R1: After reset, `irq` is 0, the status register (0x14) reads 0x0001, the enable register (0x16) reads 0x0001, and the control register (0x10) reads 0x0000.
- R2: The alarm registers read back the written fields in these places. 0x08 holds year in [15:8] and month in [3:0]. 0x0A holds day in [4:0], and its bits [15:8] always read 0. 0x0C holds hour in [12:8] and minute in [5:0]. 0x0E holds seconds in [5:0].
- R3: With control bits [3:2] = 00 (the reset value), a tick whose hour, minute and second equal the alarm sets status bit 2 at that clock edge, whatever the date fields hold.
- R4: With mode 11, the status bit sets only when second, minute, hour, day, month and year all match; a year mismatch alone prevents it.
- R5: Mode 01 requires hour, minute, second and day to match. Mode 10 also requires month to match. In both modes the year is ignored.
- R6: Equal fields without `secTick` never set the status bit.
- R7: The status bit latches while enable bit 2 is clear, with `irq` held at 0. Writing 1 to enable bit 2 then raises `irq` from the next cycle on.
- R8: Writing a word with bit 2 set to 0x14 clears the status bit. Writing 0 there leaves it set. A match in the same cycle as a clear leaves it set.
- R9: Bit 0 of the status and enable registers reads 1 even after 0 is written to it. Only bit 2 of the enable register is writable.
- R10: `irq` is high exactly when status bit 2 and enable bit 2 are both set. Clearing the enable drops `irq` but keeps the status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 5 | Write byte address |
| wrData | input | 16 | Write data |
| rdAddr | input | 5 | Read byte address |
| rdData | output | 16 | Read data (combinational) |
| secTick | input | 1 | Calendar fields were just updated |
| curYear | input | 8 | Current year offset |
| curMonth | input | 4 | Current month |
| curDay | input | 5 | Current day of month |
| curHour | input | 5 | Current hour |
| curMin | input | 6 | Current minute |
| curSec | input | 6 | Current second |
| irq | output | 1 | Alarm interrupt request |

## Verification
A register write becomes visible on `rdData` right after the rising edge that samples `wrEn`. The bench drives every stimulus on a falling edge and reads back on the next falling edge. A tick with matching fields sets the status bit at the same rising edge, so the status read and `irq` are checked one falling edge after the tick is driven. `irq` follows the enable register with no extra stage, so it is checked in the half cycle after the enable write. Negative cases first hold equal fields with no tick for several cycles and then read the status.

// File: rtl/alarm_cmp_pkg.sv
package alarm_cmp_pkg;
  parameter int DATA_W = 16;
  parameter int ADDR_W = 5;
  parameter int YEAR_W = 8;
  parameter int MON_W  = 4;
  parameter int DAY_W  = 5;
  parameter int HOUR_W = 5;
  parameter int MIN_W  = 6;
  parameter int SEC_W  = 6;
  parameter int ALM_BIT = 2;
  parameter int MODE_LSB = 2;
  localparam int HALF_W = DATA_W / 2;

  localparam logic [ADDR_W-1:0] A_ALM_YM  = 5'h08;
  localparam logic [ADDR_W-1:0] A_ALM_DAY = 5'h0A;
  localparam logic [ADDR_W-1:0] A_ALM_HM  = 5'h0C;
  localparam logic [ADDR_W-1:0] A_ALM_SEC = 5'h0E;
  localparam logic [ADDR_W-1:0] A_CTL     = 5'h10;
  localparam logic [ADDR_W-1:0] A_STAT    = 5'h14;
  localparam logic [ADDR_W-1:0] A_IEN     = 5'h16;

  typedef enum logic [1:0] {
    MATCH_HMS = 2'b00,
    MATCH_DAY = 2'b01,
    MATCH_MON = 2'b10,
    MATCH_ALL = 2'b11
  } matchMode_e;

  typedef struct packed {
    logic wrYm;
    logic wrDay;
    logic wrHm;
    logic wrSec;
    logic wrCtl;
    logic wrIen;
    logic clrAlm;
    logic setAlm;
  } strobe_t;

  typedef struct packed {
    logic sec;
    logic min;
    logic hour;
    logic day;
    logic mon;
    logic year;
  } fieldEq_t;
endpackage

// File: rtl/alarm_cmp_ctrl.sv
module alarm_cmp_ctrl
  import alarm_cmp_pkg::*;
(
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              secTick,
  input  matchMode_e        mode,
  input  fieldEq_t          fieldEq,
  output strobe_t           stb
);
  logic timeEq;
  logic hit;

  assign timeEq = fieldEq.sec && fieldEq.min && fieldEq.hour;

  always_comb begin
    unique case (mode)
      MATCH_HMS: hit = timeEq;
      MATCH_DAY: hit = timeEq && fieldEq.day;
      MATCH_MON: hit = timeEq && fieldEq.day && fieldEq.mon;
      default:   hit = timeEq && fieldEq.day && fieldEq.mon && fieldEq.year;
    endcase
  end

  always_comb begin
    stb        = '0;
    stb.wrYm   = wrEn && (wrAddr == A_ALM_YM);
    stb.wrDay  = wrEn && (wrAddr == A_ALM_DAY);
    stb.wrHm   = wrEn && (wrAddr == A_ALM_HM);
    stb.wrSec  = wrEn && (wrAddr == A_ALM_SEC);
    stb.wrCtl  = wrEn && (wrAddr == A_CTL);
    stb.wrIen  = wrEn && (wrAddr == A_IEN);
    stb.clrAlm = wrEn && (wrAddr == A_STAT) && wrData[ALM_BIT];
    stb.setAlm = secTick && hit;
  end
endmodule

// File: rtl/alarm_cmp_dp.sv
module alarm_cmp_dp
  import alarm_cmp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  strobe_t           stb,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic [YEAR_W-1:0] curYear,
  input  logic [MON_W-1:0]  curMonth,
  input  logic [DAY_W-1:0]  curDay,
  input  logic [HOUR_W-1:0] curHour,
  input  logic [MIN_W-1:0]  curMin,
  input  logic [SEC_W-1:0]  curSec,
  output matchMode_e        mode,
  output fieldEq_t          fieldEq,
  output logic [DATA_W-1:0] rdData,
  output logic              almStatus,
  output logic              almEnable,
  output logic              irq
);
  logic [YEAR_W-1:0] almYear;
  logic [MON_W-1:0]  almMonth;
  logic [DAY_W-1:0]  almDay;
  logic [HOUR_W-1:0] almHour;
  logic [MIN_W-1:0]  almMin;
  logic [SEC_W-1:0]  almSec;
  logic [DATA_W-1:0] statusVec;
  logic [DATA_W-1:0] enableVec;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      almYear   <= '0;
      almMonth  <= '0;
      almDay    <= '0;
      almHour   <= '0;
      almMin    <= '0;
      almSec    <= '0;
      mode      <= MATCH_HMS;
      almEnable <= 1'b0;
      almStatus <= 1'b0;
    end else begin
      if (stb.wrYm) begin
        almYear  <= wrData[HALF_W +: YEAR_W];
        almMonth <= wrData[0 +: MON_W];
      end
      if (stb.wrDay) almDay <= wrData[0 +: DAY_W];
      if (stb.wrHm) begin
        almHour <= wrData[HALF_W +: HOUR_W];
        almMin  <= wrData[0 +: MIN_W];
      end
      if (stb.wrSec) almSec <= wrData[0 +: SEC_W];
      if (stb.wrCtl) mode <= matchMode_e'(wrData[MODE_LSB +: 2]);
      if (stb.wrIen) almEnable <= wrData[ALM_BIT];
      if (stb.setAlm)      almStatus <= 1'b1;
      else if (stb.clrAlm) almStatus <= 1'b0;
    end
  end

  always_comb begin
    fieldEq      = '0;
    fieldEq.sec  = (curSec == almSec);
    fieldEq.min  = (curMin == almMin);
    fieldEq.hour = (curHour == almHour);
    fieldEq.day  = (curDay == almDay);
    fieldEq.mon  = (curMonth == almMonth);
    fieldEq.year = (curYear == almYear);
  end

  always_comb begin
    statusVec          = '0;
    statusVec[0]       = 1'b1;
    statusVec[ALM_BIT] = almStatus;
    enableVec          = '0;
    enableVec[0]       = 1'b1;
    enableVec[ALM_BIT] = almEnable;
  end

  assign irq = |(statusVec[DATA_W-1:1] & enableVec[DATA_W-1:1]);

  always_comb begin
    rdData = '0;
    unique case (rdAddr)
      A_ALM_YM: begin
        rdData[HALF_W +: YEAR_W] = almYear;
        rdData[0 +: MON_W]       = almMonth;
      end
      A_ALM_DAY: rdData[0 +: DAY_W] = almDay;
      A_ALM_HM: begin
        rdData[HALF_W +: HOUR_W] = almHour;
        rdData[0 +: MIN_W]       = almMin;
      end
      A_ALM_SEC: rdData[0 +: SEC_W] = almSec;
      A_CTL:     rdData[MODE_LSB +: 2] = mode;
      A_STAT:    rdData = statusVec;
      A_IEN:     rdData = enableVec;
      default:   rdData = '0;
    endcase
  end
endmodule

// File: rtl/alarm_cmp.sv
module alarm_cmp
  import alarm_cmp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData,
  input  logic              secTick,
  input  logic [YEAR_W-1:0] curYear,
  input  logic [MON_W-1:0]  curMonth,
  input  logic [DAY_W-1:0]  curDay,
  input  logic [HOUR_W-1:0] curHour,
  input  logic [MIN_W-1:0]  curMin,
  input  logic [SEC_W-1:0]  curSec,
  output logic              irq
);
  strobe_t    stb;
  matchMode_e mode;
  fieldEq_t   fieldEq;
  logic       almStatus;
  logic       almEnable;

  alarm_cmp_ctrl u_ctrl (
    .wrEn    (wrEn),
    .wrAddr  (wrAddr),
    .wrData  (wrData),
    .secTick (secTick),
    .mode    (mode),
    .fieldEq (fieldEq),
    .stb     (stb)
  );

  alarm_cmp_dp u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .stb       (stb),
    .wrData    (wrData),
    .rdAddr    (rdAddr),
    .curYear   (curYear),
    .curMonth  (curMonth),
    .curDay    (curDay),
    .curHour   (curHour),
    .curMin    (curMin),
    .curSec    (curSec),
    .mode      (mode),
    .fieldEq   (fieldEq),
    .rdData    (rdData),
    .almStatus (almStatus),
    .almEnable (almEnable),
    .irq       (irq)
  );
endmodule

// File: rtl/alarm_cmp_chk.sv
module alarm_cmp_chk
  import alarm_cmp_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              wrEn,
  input logic [ADDR_W-1:0] wrAddr,
  input logic [DATA_W-1:0] wrData,
  input logic [ADDR_W-1:0] rdAddr,
  input logic [DATA_W-1:0] rdData,
  input logic              secTick,
  input logic              almStatus,
  input logic              almEnable,
  input logic              irq
);
  logic clrWr;
  assign clrWr = wrEn && (wrAddr == A_STAT) && wrData[ALM_BIT];

  // R6: status can only rise after a sampled tick
  p_set_needs_tick_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(almStatus) |-> $past(secTick));

  // R8: clear with no tick pending empties the status
  p_w1c_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (clrWr && !secTick) |=> !almStatus);

  // R7: status is sticky without a clear write
  p_status_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (almStatus && !clrWr) |=> almStatus);

  // R10: interrupt only with the source enabled and pending
  p_irq_needs_enable_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (almEnable && almStatus));

  // R9: reserved bit of status and enable reads one
  p_reserved_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((rdAddr == A_STAT) || (rdAddr == A_IEN)) |-> rdData[0]);

  // R2: upper byte of the alarm day register reads zero
  p_day_upper_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rdAddr == A_ALM_DAY) |-> (rdData[DATA_W-1:HALF_W] == '0));
endmodule

bind alarm_cmp alarm_cmp_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wrEn      (wrEn),
  .wrAddr    (wrAddr),
  .wrData    (wrData),
  .rdAddr    (rdAddr),
  .rdData    (rdData),
  .secTick   (secTick),
  .almStatus (almStatus),
  .almEnable (almEnable),
  .irq       (irq)
);

// File: tb/alarm_cmp_tb_top.sv
module alarm_cmp_tb_top;
  localparam time CLK_PERIOD = 10ns;
  localparam logic [4:0] A_YM = 5'h08, A_DAY = 5'h0A, A_HM = 5'h0C,
                         A_SEC = 5'h0E, A_CTL = 5'h10, A_STAT = 5'h14, A_IEN = 5'h16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wrEn = 1'b0;
  logic [4:0] wrAddr = '0;
  logic [15:0] wrData = '0;
  logic [4:0] rdAddr = '0;
  logic [15:0] rdData;
  logic secTick = 1'b0;
  logic [7:0] curYear = '0;
  logic [3:0] curMonth = '0;
  logic [4:0] curDay = '0;
  logic [4:0] curHour = '0;
  logic [5:0] curMin = '0;
  logic [5:0] curSec = '0;
  logic irq;
  int vectors = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  alarm_cmp dut_i (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .secTick(secTick), .curYear(curYear),
    .curMonth(curMonth), .curDay(curDay), .curHour(curHour), .curMin(curMin),
    .curSec(curSec), .irq(irq)
  );

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(logic [4:0] a, output logic [15:0] v);
    rdAddr = a;
    #1;
    v = rdData;
  endtask

  task automatic wr(logic [4:0] a, logic [15:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic setAlarm(logic [7:0] y, logic [3:0] mo, logic [4:0] d,
                          logic [4:0] h, logic [5:0] mi, logic [5:0] s);
    wr(A_YM, {y, 4'h0, mo});
    wr(A_DAY, {11'h0, d});
    wr(A_HM, {3'h0, h, 2'h0, mi});
    wr(A_SEC, {10'h0, s});
  endtask

  task automatic tickAt(logic [7:0] y, logic [3:0] mo, logic [4:0] d,
                        logic [4:0] h, logic [5:0] mi, logic [5:0] s);
    @(negedge clk);
    curYear = y; curMonth = mo; curDay = d; curHour = h; curMin = mi; curSec = s;
    secTick = 1'b1;
    @(negedge clk);
    secTick = 1'b0;
  endtask

  task automatic clearStatus();
    wr(A_STAT, 16'h0004);
  endtask

  task automatic t_reset();
    logic [15:0] v;
    chk("R1 irq", {15'h0, irq}, 16'h0);
    rd(A_STAT, v); chk("R1 status", v, 16'h0001);
    rd(A_IEN, v);  chk("R1 enable", v, 16'h0001);
    rd(A_CTL, v);  chk("R1 control", v, 16'h0000);
  endtask

  task automatic t_regs();
    logic [15:0] v;
    wr(A_YM, 16'h2A0C);  rd(A_YM, v);  chk("R2 year/month", v, 16'h2A0C);
    wr(A_DAY, 16'hFF1F); rd(A_DAY, v); chk("R2 day reserved", v, 16'h001F);
    wr(A_HM, 16'h173B);  rd(A_HM, v);  chk("R2 hour/minute", v, 16'h173B);
    wr(A_SEC, 16'h002D); rd(A_SEC, v); chk("R2 seconds", v, 16'h002D);
  endtask

  task automatic t_daily();
    logic [15:0] v;
    wr(A_CTL, 16'h0000);
    setAlarm(8'h05, 4'h3, 5'd10, 5'd12, 6'd34, 6'd56);
    tickAt(8'h77, 4'h9, 5'd2, 5'd12, 6'd34, 6'd56);
    rd(A_STAT, v); chk("R3 daily match ignores date", v, 16'h0005);
    chk("R7 masked irq low", {15'h0, irq}, 16'h0);
    wr(A_STAT, 16'h0000);
    rd(A_STAT, v); chk("R8 write zero keeps", v, 16'h0005);
    clearStatus();
    rd(A_STAT, v); chk("R8 write one clears", v, 16'h0001);
    tickAt(8'h77, 4'h9, 5'd2, 5'd12, 6'd34, 6'd57);
    rd(A_STAT, v); chk("R3 second mismatch", v, 16'h0001);
  endtask

  task automatic t_notick();
    logic [15:0] v;
    @(negedge clk);
    curHour = 5'd12; curMin = 6'd34; curSec = 6'd56;
    repeat (5) @(negedge clk);
    rd(A_STAT, v); chk("R6 no tick no set", v, 16'h0001);
  endtask

  task automatic t_full();
    logic [15:0] v;
    wr(A_CTL, 16'h000C);
    rd(A_CTL, v); chk("R4 control readback", v, 16'h000C);
    tickAt(8'h06, 4'h3, 5'd10, 5'd12, 6'd34, 6'd56);
    rd(A_STAT, v); chk("R4 year mismatch", v, 16'h0001);
    tickAt(8'h05, 4'h3, 5'd10, 5'd12, 6'd34, 6'd56);
    rd(A_STAT, v); chk("R4 full match", v, 16'h0005);
    clearStatus();
  endtask

  task automatic t_partial();
    logic [15:0] v;
    wr(A_CTL, 16'h0004);
    tickAt(8'h40, 4'h7, 5'd10, 5'd12, 6'd34, 6'd56);
    rd(A_STAT, v); chk("R5 mode01 day match", v, 16'h0005);
    clearStatus();
    tickAt(8'h05, 4'h3, 5'd11, 5'd12, 6'd34, 6'd56);
    rd(A_STAT, v); chk("R5 mode01 day mismatch", v, 16'h0001);
    wr(A_CTL, 16'h0008);
    tickAt(8'h40, 4'h3, 5'd10, 5'd12, 6'd34, 6'd56);
    rd(A_STAT, v); chk("R5 mode10 match", v, 16'h0005);
    clearStatus();
    tickAt(8'h05, 4'h4, 5'd10, 5'd12, 6'd34, 6'd56);
    rd(A_STAT, v); chk("R5 mode10 month mismatch", v, 16'h0001);
  endtask

  task automatic t_mask();
    logic [15:0] v;
    wr(A_CTL, 16'h0000);
    tickAt(8'h00, 4'h1, 5'd1, 5'd12, 6'd34, 6'd56);
    chk("R7 latched but masked", {15'h0, irq}, 16'h0);
    wr(A_IEN, 16'h0004);
    chk("R7 unmask fires", {15'h0, irq}, 16'h1);
    rd(A_IEN, v); chk("R10 enable readback", v, 16'h0005);
    wr(A_IEN, 16'h0000);
    chk("R10 mask drops irq", {15'h0, irq}, 16'h0);
    rd(A_STAT, v); chk("R10 status kept", v, 16'h0005);
    rd(A_IEN, v); chk("R9 enable bit0 stays", v, 16'h0001);
    wr(A_IEN, 16'hFFFF);
    rd(A_IEN, v); chk("R9 only bit2 writable", v, 16'h0005);
    clearStatus();
    chk("R10 clear drops irq", {15'h0, irq}, 16'h0);
    rd(A_STAT, v); chk("R9 status bit0 stays", v, 16'h0001);
    wr(A_IEN, 16'h0000);
  endtask

  task automatic t_setwins();
    logic [15:0] v;
    @(negedge clk);
    curYear = 8'h01; curMonth = 4'h2; curDay = 5'd3;
    curHour = 5'd12; curMin = 6'd34; curSec = 6'd56;
    secTick = 1'b1; wrEn = 1'b1; wrAddr = A_STAT; wrData = 16'h0004;
    @(negedge clk);
    secTick = 1'b0; wrEn = 1'b0;
    rd(A_STAT, v); chk("R8 set wins over clear", v, 16'h0005);
    clearStatus();
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_daily();
    t_notick();
    t_full();
    t_partial();
    t_mask();
    t_setwins();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule